// File: doc/BRIEF.md
# Key-Gated Sign-Control Obfuscation Unit

This block hands the add/subtract control bits to the three processing elements of one linear systolic array, and it routes each bit through a key-selected multiplexer. Each element has one 4-to-1, one-bit multiplexer. The element's own true sign bit sits on one of the four legs. The other three legs carry true sign bits that belong to other elements, either in the same array or in neighbouring arrays. A two-bit field of the key picks the leg.

Only one key value steers every true bit to its own element. Any other key steers at least one element to a decoy. A decoy is a real control bit, so the faulty datapath output looks just as plausible as the correct one. The leg that holds the true bit is a parameter for each element, so each array instance can carry a different key. The decoy wiring is also a parameter. The unit holds no state and adds no register stage, so datapath timing does not change.

The key is held elsewhere. The arithmetic that the sign bits steer is also outside this block.

Top module: `sgn_obf_unit`

## Requirements
- R1: Each element p (p = 0, 1, 2) gets its sign from a 4-to-1 one-bit multiplexer. The leg index is sel = 2*key_i[2p] + key_i[2p+1].
- R2: The true leg positions default to 1 for element 0, 2 for element 1 and 1 for element 2. When sel equals the element's true position, sgn_o[p] equals true_sgn_i[p].
- R3: The remaining three legs of element p take decoy slots 3p, 3p+1 and 3p+2, in ascending leg order. A sel below the true position picks slot 3p+sel. A sel above it picks slot 3p+sel-1.
- R4: Each decoy slot has a source code. A code below 3 selects true_sgn_i[code]. A code of 3 or more selects ext_sgn_i[code-3]. The default codes for slots 0 to 8 are 3, 4, 1, 0, 5, 6, 7, 5, 8. Foreign bit 2 therefore feeds both element 1 and element 2, and no element ever uses its own bit as a decoy.
- R5: With key_i = 6'h26 (bits 0 to 5 equal to 0, 1, 1, 0, 0, 1), sgn_o equals true_sgn_i for every input pattern.
- R6: For every one of the other 63 key values, at least one combination of true_sgn_i and ext_sgn_i exists for which sgn_o differs from true_sgn_i.
- R7: The unit is purely combinational. sgn_o reflects the key and sign inputs within the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| key_i | input | 6 | Obfuscation key, two bits per element |
| true_sgn_i | input | 3 | True sign-control bits of this array's elements |
| ext_sgn_i | input | 6 | True sign bits from elements in other arrays, used as decoys |
| sgn_o | output | 3 | Sign bits delivered to the three elements |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies between inputs and outputs. The driver applies inputs on the falling edge and queues the expected value. The monitor compares on the next rising edge, half a period later, so the inputs have settled and have not yet changed. The stimulus sweeps all 64 keys against all 512 combinations of true and foreign sign bits. It also records, for each key, whether any mismatch against the true bits occurred. That record is judged once the sweep has finished.

// File: rtl/sgn_obf_pkg.sv
`timescale 1ns/1ps
package sgn_obf_pkg;
  localparam int unsigned MUX_IN  = 4;
  localparam int unsigned SEL_W   = $clog2(MUX_IN);
  localparam int unsigned DECOY_N = MUX_IN - 1;
  localparam int unsigned SRC_W   = 4;  // source code width, limits PE_N + EXT_N to 16
endpackage

// File: rtl/sgn_obf_route.sv
`timescale 1ns/1ps
module sgn_obf_route
  import sgn_obf_pkg::*;
#(
  parameter int unsigned PE_N  = 3,
  parameter int unsigned EXT_N = 6,
  parameter logic [SRC_W*DECOY_N*PE_N-1:0] DECOY_SRC = 36'h857650143
) (
  input  logic [PE_N-1:0]         true_sgn_i,
  input  logic [EXT_N-1:0]        ext_sgn_i,
  output logic [DECOY_N*PE_N-1:0] decoy_o
);
  localparam int unsigned SLOT_N = DECOY_N * PE_N;

  for (genvar s = 0; s < SLOT_N; s++) begin : g_slot
    localparam int unsigned SRC   = int'(DECOY_SRC[SRC_W*s +: SRC_W]);
    localparam int unsigned OWNER = s / DECOY_N;
    if (SRC >= PE_N + EXT_N) begin : g_bad_src
      $error("decoy source code out of range");
    end
    if (SRC == OWNER) begin : g_self_src
      $error("element cannot use its own sign as decoy (R4)");
    end
    if (SRC < PE_N) begin : g_local
      assign decoy_o[s] = true_sgn_i[SRC];
    end else begin : g_foreign
      assign decoy_o[s] = ext_sgn_i[SRC-PE_N];
    end
  end
endmodule

// File: rtl/sgn_obf_mux.sv
`timescale 1ns/1ps
module sgn_obf_mux
  import sgn_obf_pkg::*;
#(
  parameter int unsigned TRUE_POS = 0
) (
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               own_i,
  input  logic [DECOY_N-1:0] decoy_i,
  output logic               sgn_o
);
  localparam logic [SEL_W-1:0] TP = SEL_W'(TRUE_POS);

  logic [MUX_IN-1:0] cand;

  for (genvar j = 0; j < MUX_IN; j++) begin : g_leg
    if (j == TRUE_POS) begin : g_true
      assign cand[j] = own_i;
    end else if (j < TRUE_POS) begin : g_lo
      assign cand[j] = decoy_i[j];
    end else begin : g_hi
      assign cand[j] = decoy_i[j-1];
    end
  end

  assign sgn_o = cand[sel_i];

  // decoy rank follows leg order around the true leg
  always_comb begin
    if (sel_i < TP) begin
      p_decoy_rank_lo_r3: assert (sgn_o == decoy_i[sel_i]);
    end else if (sel_i > TP) begin
      p_decoy_rank_hi_r3: assert (sgn_o == decoy_i[sel_i - SEL_W'(1)]);
    end
  end
endmodule

// File: rtl/sgn_obf_unit.sv
`timescale 1ns/1ps
module sgn_obf_unit
  import sgn_obf_pkg::*;
#(
  parameter int unsigned PE_N  = 3,
  parameter int unsigned EXT_N = 6,
  parameter logic [SEL_W*PE_N-1:0]          TRUE_POS  = 6'b01_10_01,
  parameter logic [SRC_W*DECOY_N*PE_N-1:0]  DECOY_SRC = 36'h857650143
) (
  input  logic [SEL_W*PE_N-1:0] key_i,
  input  logic [PE_N-1:0]       true_sgn_i,
  input  logic [EXT_N-1:0]      ext_sgn_i,
  output logic [PE_N-1:0]       sgn_o
);
  localparam int unsigned KEY_W = SEL_W * PE_N;

  // key bit 2p is the select MSB of element p
  function automatic logic [KEY_W-1:0] key_from_pos();
    logic [KEY_W-1:0] k;
    k = '0;
    for (int p = 0; p < PE_N; p++) begin
      k[SEL_W*p]   = TRUE_POS[SEL_W*p+1];
      k[SEL_W*p+1] = TRUE_POS[SEL_W*p];
    end
    return k;
  endfunction

  localparam logic [KEY_W-1:0] CORRECT_KEY = key_from_pos();

  logic [DECOY_N*PE_N-1:0] decoy_w;
  logic [SEL_W-1:0]        sel_w [PE_N];

  sgn_obf_route #(
    .PE_N     (PE_N),
    .EXT_N    (EXT_N),
    .DECOY_SRC(DECOY_SRC)
  ) i_route (
    .true_sgn_i(true_sgn_i),
    .ext_sgn_i (ext_sgn_i),
    .decoy_o   (decoy_w)
  );

  for (genvar p = 0; p < PE_N; p++) begin : g_pe
    assign sel_w[p] = {key_i[SEL_W*p], key_i[SEL_W*p+1]};

    sgn_obf_mux #(
      .TRUE_POS(int'(TRUE_POS[SEL_W*p +: SEL_W]))
    ) i_mux (
      .sel_i  (sel_w[p]),
      .own_i  (true_sgn_i[p]),
      .decoy_i(decoy_w[DECOY_N*p +: DECOY_N]),
      .sgn_o  (sgn_o[p])
    );
  end

  always_comb begin
    if (key_i == CORRECT_KEY) begin
      p_correct_key_r5: assert (sgn_o == true_sgn_i);
    end
    for (int p = 0; p < PE_N; p++) begin
      if (sel_w[p] == TRUE_POS[SEL_W*p +: SEL_W]) begin
        p_true_pos_r2: assert (sgn_o[p] == true_sgn_i[p]);
      end else begin
        p_decoy_pick_r4: assert (sgn_o[p] == decoy_w[DECOY_N*p]   ||
                                 sgn_o[p] == decoy_w[DECOY_N*p+1] ||
                                 sgn_o[p] == decoy_w[DECOY_N*p+2]);
      end
    end
  end
endmodule

// File: tb/test_sgn_obf_unit.sv
`timescale 1ns/1ps
module test_sgn_obf_unit;
  localparam real HALF = 2.5;  // 200 MHz

  typedef struct packed {
    logic [5:0] key;
    logic [2:0] tru;
    logic [2:0] exp;
  } item_t;

  logic       clk = 1'b0;
  logic [5:0] key_i = '0;
  logic [2:0] true_sgn_i = '0;
  logic [5:0] ext_sgn_i = '0;
  logic [2:0] sgn_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit miss_seen [64];
  item_t q [$];

  // model tables taken from R2 and R4
  int tpos [3] = '{1, 2, 1};
  int srcs [9] = '{3, 4, 1, 0, 5, 6, 7, 5, 8};

  always #(HALF) clk = ~clk;

  sgn_obf_unit i_sgn_obf_unit (
    .key_i     (key_i),
    .true_sgn_i(true_sgn_i),
    .ext_sgn_i (ext_sgn_i),
    .sgn_o     (sgn_o)
  );

  function automatic logic [2:0] model(logic [5:0] k, logic [2:0] t, logic [5:0] e);
    logic [2:0] r;
    for (int p = 0; p < 3; p++) begin
      int sel, rank, src;
      sel = 2*int'(k[2*p]) + int'(k[2*p+1]);  // R1
      if (sel == tpos[p]) r[p] = t[p];        // R2
      else begin
        rank = (sel < tpos[p]) ? sel : sel - 1;  // R3
        src  = srcs[3*p + rank];
        r[p] = (src < 3) ? t[src] : e[src-3];    // R4
      end
    end
    return r;
  endfunction

  task automatic drive(logic [5:0] k, logic [2:0] t, logic [5:0] e);
    item_t it;
    @(negedge clk);
    key_i = k; true_sgn_i = t; ext_sgn_i = e;
    it.key = k; it.tru = t; it.exp = model(k, t, e);
    q.push_back(it);
  endtask

  // monitor: result due same cycle (R7), sampled half a period after drive
  always @(posedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (sgn_o !== it.exp) begin
        fails++;
        $display("FAIL R1/R7 key=%h: sgn_o=%b expected=%b", it.key, sgn_o, it.exp);
      end
      if (sgn_o !== it.tru) miss_seen[it.key] = 1'b1;
    end
  end

  initial begin
    for (int k = 0; k < 64; k++) miss_seen[k] = 1'b0;
    // idle state with all-zero inputs
    drive(6'h00, 3'b000, 6'h00);
    // every key against every sign pattern
    for (int k = 0; k < 64; k++)
      for (int v = 0; v < 512; v++)
        drive(6'(k), v[2:0], v[8:3]);
    @(negedge clk);
    @(negedge clk);
    // R5: correct key never mismatches the true bits
    checks++;
    if (miss_seen[6'h26]) begin
      fails++;
      $display("FAIL R5 key=26: mismatch_seen=1 expected=0");
    end
    // R6: every other key yields some wrong sign
    for (int k = 0; k < 64; k++) begin
      if (k != 'h26) begin
        checks++;
        if (!miss_seen[k]) begin
          fails++;
          $display("FAIL R6 key=%h: mismatch_seen=0 expected=1", k[5:0]);
        end
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(HALF*2*150000);
        fails++;
        $display("FAIL watchdog: done=0 expected=1");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule